// File: doc/BRIEF.md
# Cache-Block Permission Checker

This block sits next to the local page translation and judges every memory reference against per-block access rights. A page is divided into fixed-size cache blocks, and the translation entry for the page carries a 2-bit state for each of them. For the block a request addresses, the checker picks out that block's state. It then either lets the load or store go ahead or rejects it. An accepted store to a clean writable block marks that block as written.

A rejected reference does not stall the issuing thread. Instead, the checker captures a fault record one cycle later: the word address, the direction, and a small tag naming the destination register. A downstream event queue collects that record. Software can overwrite the state of any single block through a separate write port. When that write lands in the same cycle as a hardware dirty update, the software write takes effect. The updated state vector is presented combinationally so that the translation entry can be written back.

Top module: `blk_status_chk`

## Requirements
- R1: The block index is the word address bits [8:3] with default parameters (8-word blocks, 512-word pages), and block n's state occupies bits [2n+1:2n] of the status vector. The state codes are 00 no access, 01 read only, 10 writable clean, 11 written. Address bits above the page offset do not affect the decision.
- R2: A valid read is allowed in states 01, 10 and 11, and it faults in state 00.
- R3: A valid write is allowed in states 10 and 11, and it faults in states 00 and 01.
- R4: An allowed write to a block in state 10 sets that block to 11 on `stat_o` in the same cycle, and no other block changes.
- R5: An allowed read, or an allowed write to a block already in state 11, leaves `stat_o` equal to `stat_i`.
- R6: A faulting reference leaves `stat_o` equal to `stat_i`.
- R7: On the clock edge that ends a faulting cycle, `flt_vld_o` rises for exactly one cycle. `flt_addr_o`, `flt_wr_o` and `flt_tag_o` then show the faulting request's address, direction and tag, and they keep those values until the next fault.
- R8: A software write sets only the selected block's state on `stat_o`. It overrides a hardware dirty update to the same block in the same cycle.
- R9: With no valid request, `allow_o` and `fault_o` are low and `stat_o` equals `stat_i`, unless a software write is applied.
- R10: After reset, `flt_vld_o` is low and all fault record fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld_i | input | 1 | Reference present this cycle |
| req_wr_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W (32) | Word address of the reference |
| req_tag_i | input | TAG_W (4) | Destination register tag |
| stat_i | input | 2*PAGE_WORDS/BLK_WORDS (128) | State vector of the mapped page |
| sw_we_i | input | 1 | Software state write enable |
| sw_idx_i | input | log2 blocks (6) | Block selected by software |
| sw_stat_i | input | 2 | State written by software |
| allow_o | output | 1 | Reference may proceed |
| fault_o | output | 1 | Reference rejected |
| stat_o | output | 2*PAGE_WORDS/BLK_WORDS (128) | Updated state vector |
| flt_vld_o | output | 1 | Fault record valid (one cycle) |
| flt_addr_o | output | ADDR_W (32) | Faulting word address |
| flt_wr_o | output | 1 | Faulting direction |
| flt_tag_o | output | TAG_W (4) | Faulting destination tag |

## Verification
The bench builds the checker with its defaults: 32-bit addresses, 8-word blocks, 512-word pages, 4-bit tags, and record fields held between faults. With those values the page has 64 blocks, so the bench can address the last index (63) as well as block 0. High page-number bits are set in every address, which exposes any index that is taken from the wrong bits. The page pattern cycles through all four states, so one walk over the blocks covers every state against both directions.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
   typedef enum logic [1:0] {
      BS_NOACC = 2'b00,
      BS_RDONLY = 2'b01,
      BS_CLEAN = 2'b10,
      BS_WRITTEN = 2'b11
   } blk_state_e;
endpackage

// File: rtl/bsc_index.sv
module bsc_index #(
   parameter int ADDR_W = 32,
   parameter int OFS_W = 3,
   parameter int IDX_W = 6,
   parameter int VEC_W = 128
) (
   input logic [ADDR_W-1:0] addr_i,
   input logic [VEC_W-1:0] vec_i,
   output logic [IDX_W-1:0] idx_o,
   output bsc_pkg::blk_state_e state_o
);
   initial begin
      if (VEC_W != 2 * (1 << IDX_W))
         $error("bsc_index: VEC_W must hold two bits per block");
      if (ADDR_W < OFS_W + IDX_W)
         $error("bsc_index: address too narrow for page offset");
   end

   assign idx_o = addr_i[OFS_W +: IDX_W];
   assign state_o = bsc_pkg::blk_state_e'(vec_i[{idx_o, 1'b0} +: 2]);
endmodule

// File: rtl/bsc_policy.sv
module bsc_policy (
   input logic clk,
   input logic rst_n,
   input logic vld_i,
   input logic wr_i,
   input bsc_pkg::blk_state_e state_i,
   output logic allow_o,
   output logic fault_o,
   output logic mark_o
);
   import bsc_pkg::*;

   logic permit;

   always_comb begin
      unique case (state_i)
         BS_NOACC: permit = 1'b0;
         BS_RDONLY: permit = !wr_i;
         BS_CLEAN: permit = 1'b1;
         BS_WRITTEN: permit = 1'b1;
         default: permit = 1'b0;
      endcase
   end

   assign allow_o = vld_i && permit;
   assign fault_o = vld_i && !permit;
   assign mark_o = allow_o && wr_i && (state_i == BS_CLEAN);

   // R2
   rd_noacc_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && !wr_i && state_i == BS_NOACC) |-> (fault_o && !allow_o));
   // R3
   wr_rdonly_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && wr_i && state_i == BS_RDONLY) |-> (fault_o && !allow_o));
   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |-> (!allow_o && !fault_o));
endmodule

// File: rtl/bsc_update.sv
module bsc_update #(
   parameter int IDX_W = 6,
   parameter int NBLK = 64,
   parameter int VEC_W = 128
) (
   input logic clk,
   input logic rst_n,
   input logic [VEC_W-1:0] vec_i,
   input logic mark_i,
   input logic [IDX_W-1:0] hw_idx_i,
   input logic sw_we_i,
   input logic [IDX_W-1:0] sw_idx_i,
   input logic [1:0] sw_stat_i,
   output logic [VEC_W-1:0] vec_o
);
   import bsc_pkg::*;

   initial begin
      if (NBLK != (1 << IDX_W)) $error("bsc_update: NBLK must be 2**IDX_W");
      if (VEC_W != 2 * NBLK) $error("bsc_update: VEC_W must be 2*NBLK");
   end

   for (genvar b = 0; b < NBLK; b++) begin : g_blk
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(b);
      logic [1:0] nxt;
      always_comb begin
         if (sw_we_i && sw_idx_i == MY_IDX) nxt = sw_stat_i;
         else if (mark_i && hw_idx_i == MY_IDX) nxt = BS_WRITTEN;
         else nxt = vec_i[2*b +: 2];
      end
      assign vec_o[2*b +: 2] = nxt;
   end

   // R8
   sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_we_i |-> (vec_o[{sw_idx_i, 1'b0} +: 2] == sw_stat_i));
   // R4
   mark_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_i && !(sw_we_i && sw_idx_i == hw_idx_i))
         |-> (vec_o[{hw_idx_i, 1'b0} +: 2] == 2'b11));
endmodule

// File: rtl/bsc_fault_rec.sv
module bsc_fault_rec #(
   parameter int ADDR_W = 32,
   parameter int TAG_W = 4,
   parameter bit CLEAR_IDLE = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic fault_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic wr_i,
   input logic [TAG_W-1:0] tag_i,
   output logic vld_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic wr_o,
   output logic [TAG_W-1:0] tag_o
);
   initial begin
      if (TAG_W < 1) $error("bsc_fault_rec: TAG_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_o <= 1'b0;
      else vld_o <= fault_i;
   end

   if (CLEAR_IDLE) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n || !fault_i) begin
            addr_o <= '0;
            wr_o <= 1'b0;
            tag_o <= '0;
         end else begin
            addr_o <= addr_i;
            wr_o <= wr_i;
            tag_o <= tag_i;
         end
      end
   end else begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_o <= '0;
            wr_o <= 1'b0;
            tag_o <= '0;
         end else if (fault_i) begin
            addr_o <= addr_i;
            wr_o <= wr_i;
            tag_o <= tag_i;
         end
      end
   end

   // R7
   rec_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_i |=> (vld_o && addr_o == $past(addr_i) && wr_o == $past(wr_i)
                   && tag_o == $past(tag_i)));
   // R7
   rec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_i |=> !vld_o);
endmodule

// File: rtl/blk_status_chk.sv
module blk_status_chk #(
   parameter int ADDR_W = 32,
   parameter int BLK_WORDS = 8,
   parameter int PAGE_WORDS = 512,
   parameter int TAG_W = 4,
   parameter bit CLEAR_IDLE = 1'b0,
   localparam int OFS_W = $clog2(BLK_WORDS),
   localparam int NBLK = PAGE_WORDS / BLK_WORDS,
   localparam int IDX_W = $clog2(NBLK),
   localparam int VEC_W = 2 * NBLK
) (
   input logic clk,
   input logic rst_n,
   input logic req_vld_i,
   input logic req_wr_i,
   input logic [ADDR_W-1:0] req_addr_i,
   input logic [TAG_W-1:0] req_tag_i,
   input logic [VEC_W-1:0] stat_i,
   input logic sw_we_i,
   input logic [IDX_W-1:0] sw_idx_i,
   input logic [1:0] sw_stat_i,
   output logic allow_o,
   output logic fault_o,
   output logic [VEC_W-1:0] stat_o,
   output logic flt_vld_o,
   output logic [ADDR_W-1:0] flt_addr_o,
   output logic flt_wr_o,
   output logic [TAG_W-1:0] flt_tag_o
);
   initial begin
      if ((1 << OFS_W) != BLK_WORDS) $error("blk_status_chk: BLK_WORDS not a power of two");
      if ((1 << IDX_W) != NBLK || NBLK < 2) $error("blk_status_chk: bad PAGE_WORDS");
      if (ADDR_W < OFS_W + IDX_W) $error("blk_status_chk: ADDR_W too small");
   end

   logic [IDX_W-1:0] hw_idx;
   bsc_pkg::blk_state_e cur_state;
   logic mark;

   bsc_index #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .VEC_W(VEC_W)) u_index (
      .addr_i(req_addr_i), .vec_i(stat_i), .idx_o(hw_idx), .state_o(cur_state));

   bsc_policy u_policy (
      .clk(clk), .rst_n(rst_n), .vld_i(req_vld_i), .wr_i(req_wr_i),
      .state_i(cur_state), .allow_o(allow_o), .fault_o(fault_o), .mark_o(mark));

   bsc_update #(.IDX_W(IDX_W), .NBLK(NBLK), .VEC_W(VEC_W)) u_update (
      .clk(clk), .rst_n(rst_n), .vec_i(stat_i), .mark_i(mark), .hw_idx_i(hw_idx),
      .sw_we_i(sw_we_i), .sw_idx_i(sw_idx_i), .sw_stat_i(sw_stat_i), .vec_o(stat_o));

   bsc_fault_rec #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .CLEAR_IDLE(CLEAR_IDLE)) u_rec (
      .clk(clk), .rst_n(rst_n), .fault_i(fault_o), .addr_i(req_addr_i),
      .wr_i(req_wr_i), .tag_i(req_tag_i), .vld_o(flt_vld_o), .addr_o(flt_addr_o),
      .wr_o(flt_wr_o), .tag_o(flt_tag_o));

   // R6
   fault_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o && !sw_we_i) |-> (stat_o == stat_i));
   // R9
   idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_vld_i && !sw_we_i) |-> (stat_o == stat_i));
   // R2
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(allow_o && fault_o));
endmodule

// File: tb/test_blk_status_chk.sv
module test_blk_status_chk;
   localparam int VW = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_vld = 1'b0, req_wr = 1'b0;
   logic [31:0] req_addr = '0;
   logic [3:0] req_tag = '0;
   logic [VW-1:0] stat_in = '0;
   logic sw_we = 1'b0;
   logic [5:0] sw_idx = '0;
   logic [1:0] sw_stat = '0;
   logic allow, fault, flt_vld, flt_wr;
   logic [VW-1:0] stat_out;
   logic [31:0] flt_addr;
   logic [3:0] flt_tag;
   int checks = 0, errors = 0;

   always #4 clk = !clk;

   blk_status_chk i_blk_status_chk (
      .clk(clk), .rst_n(rst_n), .req_vld_i(req_vld), .req_wr_i(req_wr),
      .req_addr_i(req_addr), .req_tag_i(req_tag), .stat_i(stat_in),
      .sw_we_i(sw_we), .sw_idx_i(sw_idx), .sw_stat_i(sw_stat),
      .allow_o(allow), .fault_o(fault), .stat_o(stat_out), .flt_vld_o(flt_vld),
      .flt_addr_o(flt_addr), .flt_wr_o(flt_wr), .flt_tag_o(flt_tag));

   task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [VW-1:0] pattern();
      logic [VW-1:0] v;
      for (int i = 0; i < 64; i++) v[2*i +: 2] = 2'(i % 4);
      return v;
   endfunction

   function automatic logic [VW-1:0] setblk(input logic [VW-1:0] v, input int b, input logic [1:0] s);
      logic [VW-1:0] r = v;
      r[2*b +: 2] = s;
      return r;
   endfunction

   function automatic logic [31:0] addr_of(input int b, input int ofs);
      return 32'hABC0_0000 | 32'(b << 3) | 32'(ofs);
   endfunction

   task automatic drive(input logic v, input logic w, input int b, input int tag);
      @(negedge clk);
      req_vld = v; req_wr = w; req_addr = addr_of(b, (b * 3) % 8); req_tag = 4'(tag);
      #2;
   endtask

   task automatic t_reset();
      chk("R10 flt_vld", VW'(flt_vld), '0);
      chk("R10 flt_addr", VW'(flt_addr), '0);
      chk("R10 flt_wr_tag", VW'({flt_wr, flt_tag}), '0);
   endtask

   task automatic t_access();
      for (int b = 0; b < 64; b += 5) begin
         int st = b % 4;
         drive(1'b1, 1'b0, b, 0);
         chk("R2 read allow", VW'(allow), VW'(st != 0));
         chk("R2 read fault", VW'(fault), VW'(st == 0));
         chk("R5 R6 read vec", stat_out, stat_in);
         drive(1'b1, 1'b1, b, 0);
         chk("R3 write allow", VW'(allow), VW'(st >= 2));
         chk("R3 write fault", VW'(fault), VW'(st < 2));
         if (st == 2) chk("R4 dirty mark", stat_out, setblk(stat_in, b, 2'b11));
         else chk("R5 R6 write vec", stat_out, stat_in);
      end
      drive(1'b1, 1'b1, 63, 0);
      chk("R1 top block written allow", VW'(allow), 1);
      drive(1'b1, 1'b1, 62, 0);
      chk("R1 R4 block 62 dirty", stat_out, setblk(stat_in, 62, 2'b11));
   endtask

   task automatic t_record();
      drive(1'b1, 1'b1, 5, 9);
      chk("R3 ro write fault", VW'(fault), 1);
      drive(1'b0, 1'b0, 0, 0);
      chk("R7 rec vld", VW'(flt_vld), 1);
      chk("R7 rec addr", VW'(flt_addr), VW'(addr_of(5, 7)));
      chk("R7 rec wr tag", VW'({flt_wr, flt_tag}), VW'({1'b1, 4'd9}));
      drive(1'b0, 1'b0, 0, 0);
      chk("R7 rec one cycle", VW'(flt_vld), 0);
      chk("R7 rec held", VW'(flt_addr), VW'(addr_of(5, 7)));
      drive(1'b1, 1'b0, 8, 3);
      drive(1'b0, 1'b0, 0, 0);
      chk("R7 rec read fault", VW'({flt_vld, flt_wr, flt_tag}), VW'({1'b1, 1'b0, 4'd3}));
      chk("R7 rec read addr", VW'(flt_addr), VW'(addr_of(8, 0)));
   endtask

   task automatic t_soft();
      @(negedge clk);
      sw_we = 1'b1; sw_idx = 6'd1; sw_stat = 2'b10;
      #2;
      chk("R9 R8 idle sw write", stat_out, setblk(stat_in, 1, 2'b10));
      chk("R9 idle outputs", VW'({allow, fault}), 0);
      drive(1'b1, 1'b1, 6, 0);
      chk("R4 R8 other blocks", stat_out, setblk(setblk(stat_in, 1, 2'b10), 6, 2'b11));
      @(negedge clk);
      sw_idx = 6'd6; sw_stat = 2'b01;
      #2;
      chk("R8 sw over dirty", stat_out, setblk(stat_in, 6, 2'b01));
      @(negedge clk);
      sw_we = 1'b0;
      req_vld = 1'b0;
      #2;
      chk("R9 idle pass", stat_out, stat_in);
   endtask

   initial begin
      #(8 * 100000);
      errors++; checks++;
      $display("FAIL watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      stat_in = pattern();
      #3;
      t_reset();
      #10 rst_n = 1'b1;
      t_access();
      t_record();
      t_soft();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule